// File: doc/BRIEF.md
# Programmable chip-select address decoder

The decoder steers each access on a 30-bit byte address onto one of eight external memory regions. Every region owns a small configuration word with a base, a size mask and an enable flag. An incoming request is compared against all enabled regions in parallel. When exactly one region claims the address, the matching chip-select line is raised one cycle later. When no region claims it, or when two or more regions claim it, nothing is forwarded and an access-error pulse is produced instead.

The first error is also latched, together with its address and its vector of claiming regions, in a sticky status register. Software clears that register with a one-cycle clear strobe.

Software sets up regions through a word-wide write port. It reads them back through a combinational read port. While a region is enabled, its base and mask are frozen. A request to disable a region is held back for as long as that region's busy input reports outstanding traffic.

Top module: `cs_addr_decoder`

## Requirements
- R1: A region claims an address when its enable is set, address bits 29..28 equal base bits 5..4, and for each n in 0..3 either mask bit n is 0 or address bit 24+n equals base bit n.
- R2: A request claimed by exactly one region drives `cs_o` with only that region's bit set, and `cs_valid_o` high, in the cycle after the request edge, with `err_o` low.
- R3: A request claimed by no region produces `err_o` high for one cycle in the cycle after the request edge, with `cs_o` all zero.
- R4: A request claimed by two or more regions produces `err_o` high and `cs_o` all zero. An address claimed by only one of those regions is still forwarded.
- R5: After reset, region 0 is enabled with base 0 and mask 0000, regions 1..7 read as all zero, and the outputs and the error status are clear.
- R6: While a region is enabled, writes do not change its base or mask. Readback and decoding stay as before.
- R7: Writing a word with bit 6 clear to an enabled region disables it at once if its busy input is low. Otherwise the disable is held and applied in the first cycle busy is low. Until then, readback shows bit 6 set and the region still decodes.
- R8: Regions 0 and 1 treat mask 0000 as a 256 MB region. Regions 2..7 decode mask 0000 as 1000 (128 MB), while readback returns the stored 0000.
- R9: On an error with the status flag clear, the address and claiming-region vector are captured and the flag is set. Later errors leave them unchanged until `err_clr_i` clears the flag. An error in the same cycle as the clear is captured.
- R10: The configuration word holds base in bits 5..0, enable in bit 6 and mask in bits 11..8. Bit 7 is not stored and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 3 | Region selected for write and readback |
| cfg_wdata_i | input | 12 | Configuration word to write |
| cfg_rdata_o | output | 12 | Configuration word of the selected region |
| busy_i | input | 8 | Per-region outstanding-access indication |
| req_i | input | 1 | Access request |
| addr_i | input | 30 | Access byte address |
| cs_o | output | 8 | Registered one-hot chip-select |
| cs_valid_o | output | 1 | A chip-select is active |
| err_o | output | 1 | Registered access-error pulse |
| err_clr_i | input | 1 | Clear strobe for the error status |
| err_flag_o | output | 1 | Sticky error-status flag |
| err_addr_o | output | 30 | Captured address of the first error |
| err_hits_o | output | 8 | Captured claiming-region vector of the first error |

## Verification
The assertions take it for granted that the busy inputs eventually fall, because a deferred disable is only checked for not happening early. They also assume that requests and configuration writes do not land in the same cycle, so that each decision refers to one settled configuration. The stimulus never overlaps a write with a request. It raises busy only on the region under test and releases it after a few cycles. It uses only the mask codes the size table allows, apart from the 0000 clamp that R8 exercises.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int BASE_W   = 6;
  localparam int MASK_W   = 4;
  localparam int CFG_W    = 12;
  localparam int EN_BIT   = 6;
  localparam int MASK_LSB = 8;
  // bits kept in the stored word; enable is held separately, bit 7 dropped
  localparam logic [CFG_W-1:0] FIELD_KEEP = 12'hF3F;

  function automatic logic [MASK_W-1:0] eff_mask(input logic [MASK_W-1:0] m, input logic wide);
    if (!wide && m == '0) return {1'b1, {(MASK_W-1){1'b0}}};
    return m;
  endfunction
endpackage

// File: rtl/cs_region_cfg.sv
module cs_region_cfg
  import cs_dec_pkg::*;
#(
  parameter logic RESET_EN = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [CFG_W-1:0]    wdata_i,
  input  logic                busy_i,
  output logic [BASE_W-1:0]   base_o,
  output logic [MASK_W-1:0]   mask_o,
  output logic                en_o,
  output logic [CFG_W-1:0]    rdata_o
);
  logic [CFG_W-1:0] word_q;
  logic             en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      en_q   <= RESET_EN;
      pend_q <= 1'b0;
    end else if (wr_i) begin
      if (!en_q) begin
        word_q <= wdata_i & FIELD_KEEP;
        en_q   <= wdata_i[EN_BIT];
        pend_q <= 1'b0;
      end else if (!wdata_i[EN_BIT]) begin
        // disable request: defer while traffic is outstanding
        if (busy_i) pend_q <= 1'b1;
        else begin
          en_q   <= 1'b0;
          pend_q <= 1'b0;
        end
      end else begin
        pend_q <= 1'b0;
      end
    end else if (pend_q && !busy_i) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end
  end

  assign base_o  = word_q[BASE_W-1:0];
  assign mask_o  = word_q[MASK_LSB +: MASK_W];
  assign en_o    = en_q;
  assign rdata_o = word_q | (CFG_W'(en_q) << EN_BIT);
endmodule

// File: rtl/cs_region_match.sv
module cs_region_match
  import cs_dec_pkg::*;
#(
  parameter int   ADDR_W = 30,
  parameter logic WIDE   = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              en_i,
  output logic              hit_o
);
  localparam int FIX_W = BASE_W - MASK_W;

  logic [BASE_W-1:0] diff;
  logic [MASK_W-1:0] mask_eff;

  assign diff     = addr_i[ADDR_W-1 -: BASE_W] ^ base_i;
  assign mask_eff = eff_mask(mask_i, WIDE);
  assign hit_o    = en_i && (diff[BASE_W-1 -: FIX_W] == '0) && ((diff[MASK_W-1:0] & mask_eff) == '0);
endmodule

// File: rtl/cs_err_status.sv
module cs_err_status #(
  parameter int ADDR_W = 30,
  parameter int NUM_REGIONS = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   err_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NUM_REGIONS-1:0] hits_i,
  input  logic                   clr_i,
  output logic                   flag_o,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [NUM_REGIONS-1:0] hits_o
);
  logic                   flag_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [NUM_REGIONS-1:0] hits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      hits_q <= '0;
    end else if (err_i && (!flag_q || clr_i)) begin
      flag_q <= 1'b1;
      addr_q <= addr_i;
      hits_q <= hits_i;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign addr_o = addr_q;
  assign hits_o = hits_q;
endmodule

// File: rtl/cs_addr_decoder.sv
module cs_addr_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_REGIONS  = 8,
  parameter int ADDR_W       = 30,
  parameter int WIDE_REGIONS = 2,
  localparam int IDX_W       = $clog2(NUM_REGIONS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [IDX_W-1:0]       cfg_idx_i,
  input  logic [CFG_W-1:0]       cfg_wdata_i,
  output logic [CFG_W-1:0]       cfg_rdata_o,
  input  logic [NUM_REGIONS-1:0] busy_i,
  input  logic                   req_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [NUM_REGIONS-1:0] cs_o,
  output logic                   cs_valid_o,
  output logic                   err_o,
  input  logic                   err_clr_i,
  output logic                   err_flag_o,
  output logic [ADDR_W-1:0]      err_addr_o,
  output logic [NUM_REGIONS-1:0] err_hits_o
);
  logic [NUM_REGIONS-1:0]        region_en;
  logic [NUM_REGIONS-1:0]        region_hit;
  logic [NUM_REGIONS*BASE_W-1:0] region_base;
  logic [NUM_REGIONS*MASK_W-1:0] region_mask;
  logic [CFG_W-1:0]              region_rd [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    cs_region_cfg #(
      .RESET_EN (g == 0)
    ) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
      .wdata_i (cfg_wdata_i),
      .busy_i  (busy_i[g]),
      .base_o  (region_base[g*BASE_W +: BASE_W]),
      .mask_o  (region_mask[g*MASK_W +: MASK_W]),
      .en_o    (region_en[g]),
      .rdata_o (region_rd[g])
    );

    cs_region_match #(
      .ADDR_W (ADDR_W),
      .WIDE   (g < WIDE_REGIONS)
    ) u_match (
      .addr_i (addr_i),
      .base_i (region_base[g*BASE_W +: BASE_W]),
      .mask_i (region_mask[g*MASK_W +: MASK_W]),
      .en_i   (region_en[g]),
      .hit_o  (region_hit[g])
    );
  end

  assign cfg_rdata_o = region_rd[cfg_idx_i];

  logic single_hit, req_err;
  assign single_hit = (region_hit != '0) && ((region_hit & (region_hit - 1'b1)) == '0);
  assign req_err    = req_i && !single_hit;

  logic [NUM_REGIONS-1:0] cs_q;
  logic                   err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= '0;
      err_q <= 1'b0;
    end else begin
      cs_q  <= (req_i && single_hit) ? region_hit : '0;
      err_q <= req_err;
    end
  end

  assign cs_o       = cs_q;
  assign cs_valid_o = |cs_q;
  assign err_o      = err_q;

  cs_err_status #(
    .ADDR_W      (ADDR_W),
    .NUM_REGIONS (NUM_REGIONS)
  ) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .err_i  (req_err),
    .addr_i (addr_i),
    .hits_i (region_hit),
    .clr_i  (err_clr_i),
    .flag_o (err_flag_o),
    .addr_o (err_addr_o),
    .hits_o (err_hits_o)
  );
endmodule

// File: rtl/cs_addr_decoder_chk.sv
module cs_addr_decoder_chk #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 30,
  parameter int BASE_W      = 6
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_i,
  input logic [NUM_REGIONS-1:0]        cs_o,
  input logic                          cs_valid_o,
  input logic                          err_o,
  input logic [NUM_REGIONS-1:0]        busy_i,
  input logic [NUM_REGIONS-1:0]        en_vec,
  input logic [NUM_REGIONS*BASE_W-1:0] base_vec,
  input logic                          err_flag_o,
  input logic                          err_clr_i,
  input logic [ADDR_W-1:0]             err_addr_o,
  input logic [NUM_REGIONS-1:0]        err_hits_o
);
  // R2
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(cs_o));

  // R2
  req_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (cs_valid_o != err_o));

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!cs_valid_o && !err_o));

  // R4
  err_blocks_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_o == '0));

  // R9
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flag_o && !err_clr_i) |=> (err_flag_o && $stable(err_addr_o) && $stable(err_hits_o)));

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg_chk
    // R7
    busy_keeps_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_vec[g] && busy_i[g]) |=> en_vec[g]);

    // R6
    base_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_vec[g] |=> $stable(base_vec[g*BASE_W +: BASE_W]));
  end
endmodule

bind cs_addr_decoder cs_addr_decoder_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .ADDR_W      (ADDR_W),
  .BASE_W      (cs_dec_pkg::BASE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .cs_o       (cs_o),
  .cs_valid_o (cs_valid_o),
  .err_o      (err_o),
  .busy_i     (busy_i),
  .en_vec     (region_en),
  .base_vec   (region_base),
  .err_flag_o (err_flag_o),
  .err_clr_i  (err_clr_i),
  .err_addr_o (err_addr_o),
  .err_hits_o (err_hits_o)
);

// File: tb/cs_addr_decoder_bench.sv
module cs_addr_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;
  localparam int AW = 30;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [2:0]    cfg_idx_i = '0;
  logic [11:0]   cfg_wdata_i = '0;
  logic [11:0]   cfg_rdata_o;
  logic [NR-1:0] busy_i = '0;
  logic          req_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [NR-1:0] cs_o;
  logic          cs_valid_o, err_o;
  logic          err_clr_i = 1'b0;
  logic          err_flag_o;
  logic [AW-1:0] err_addr_o;
  logic [NR-1:0] err_hits_o;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cs_addr_decoder u_cs_addr_decoder (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_wdata_i, .cfg_rdata_o,
    .busy_i, .req_i, .addr_i, .cs_o, .cs_valid_o, .err_o,
    .err_clr_i, .err_flag_o, .err_addr_o, .err_hits_o
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bench model of region state
  logic [11:0] m_word [NR];
  logic        m_en   [NR];

  function automatic logic [NR-1:0] model_hits(input logic [AW-1:0] a);
    logic [NR-1:0] h;
    logic [3:0] mk;
    logic [5:0] b;
    h = '0;
    for (int k = 0; k < NR; k++) begin
      b  = m_word[k][5:0];
      mk = m_word[k][11:8];
      if (k >= 2 && mk == 4'b0000) mk = 4'b1000;
      if (m_en[k] && a[29:28] == b[5:4] && (((a[27:24] ^ b[3:0]) & mk) == 4'b0000)) h[k] = 1'b1;
    end
    return h;
  endfunction

  typedef struct {
    logic [NR-1:0] cs;
    logic          err;
    string         tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  task automatic do_req(input logic [AW-1:0] a, input string tag);
    sb_item_t it;
    logic [NR-1:0] h;
    h = model_hits(a);
    it.tag = tag;
    if ($countones(h) == 1) begin it.cs = h; it.err = 1'b0; end
    else begin it.cs = '0; it.err = 1'b1; end
    sb_q.push_back(it);
    @(negedge clk_i); req_i = 1'b1; addr_i = a;
    @(negedge clk_i); req_i = 1'b0;
  endtask

  // monitor
  always @(posedge clk_i) begin
    if (rst_ni && req_i) begin
      sb_item_t e;
      #1;
      if (sb_q.size() == 0) check(1'b0, "R2 scoreboard underflow", 32'(cs_o), 32'h0);
      else begin
        e = sb_q.pop_front();
        check(cs_o == e.cs && cs_valid_o == (e.cs != '0), e.tag, 32'(cs_o), 32'(e.cs));
        check(err_o == e.err, e.tag, 32'(err_o), 32'(e.err));
      end
    end
  end

  task automatic do_cfg(input int idx, input logic [11:0] w);
    if (!m_en[idx]) begin
      m_word[idx] = w & 12'hF3F;
      m_en[idx]   = w[6];
    end else if (!w[6] && !busy_i[idx]) begin
      m_en[idx] = 1'b0;
    end
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_idx_i = 3'(idx); cfg_wdata_i = w;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic chk_rd(input int idx, input logic [11:0] exp, input string tag);
    cfg_idx_i = 3'(idx);
    #1;
    check(cfg_rdata_o == exp, tag, 32'(cfg_rdata_o), 32'(exp));
  endtask

  task automatic chk_status(input logic f, input logic [AW-1:0] a, input logic [NR-1:0] h, input string tag);
    check(err_flag_o == f, tag, 32'(err_flag_o), 32'(f));
    if (f) begin
      check(err_addr_o == a, tag, 32'(err_addr_o), 32'(a));
      check(err_hits_o == h, tag, 32'(err_hits_o), 32'(h));
    end
  endtask

  task automatic err_clear();
    @(negedge clk_i); err_clr_i = 1'b1;
    @(negedge clk_i); err_clr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NR; k++) begin m_word[k] = '0; m_en[k] = (k == 0); end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 R10: reset contents
    for (int k = 0; k < NR; k++) chk_rd(k, (k == 0) ? 12'h040 : 12'h000, "R5 reset readback");
    check(cs_o == '0 && !cs_valid_o && !err_o, "R5 outputs idle", 32'(cs_o), 32'h0);
    check(!err_flag_o, "R5 status clear", 32'(err_flag_o), 32'h0);

    // R1 R2: region 0 default claims low 256 MB
    do_req(30'h0123_4567, "R2 single hit region0");
    do_req(30'h0F00_0000, "R1 region0 top of 256MB");

    // R3 R9: no match
    do_req(30'h1000_0000, "R3 no match");
    chk_status(1'b1, 30'h1000_0000, '0, "R9 first capture");

    // R10 R1: region1, 128 MB at 0x1000_0000
    do_cfg(1, 12'h850);
    chk_rd(1, 12'h850, "R10 region1 readback");
    do_req(30'h1400_0000, "R1 region1 hit");
    do_req(30'h1800_0000, "R1 region1 A27 excluded");
    chk_status(1'b1, 30'h1000_0000, '0, "R9 status held");
    err_clear();
    chk_status(1'b0, '0, '0, "R9 status cleared");

    // R6: locked while enabled
    do_cfg(1, 12'h060);
    chk_rd(1, 12'h850, "R6 write ignored");
    do_req(30'h1400_0000, "R6 decode unchanged");

    // R8: narrow region with mask 0000
    do_cfg(2, 12'h060);
    chk_rd(2, 12'h060, "R8 stored mask readback");
    do_req(30'h2000_0000, "R8 region2 hit");
    do_req(30'h2800_0000, "R8 region2 clamped to 128MB");
    chk_status(1'b1, 30'h2800_0000, '0, "R9 capture after clear");
    err_clear();

    // R4: overlap of region3 with region0
    do_cfg(3, 12'hF40);
    do_req(30'h0000_1000, "R4 overlap");
    chk_status(1'b1, 30'h0000_1000, 8'h09, "R4 R9 overlap hits");
    err_clear();
    do_req(30'h0100_0000, "R4 outside overlap");

    // R7: deferred disable
    @(negedge clk_i); busy_i[3] = 1'b1;
    do_cfg(3, 12'hF00);
    chk_rd(3, 12'hF40, "R7 pending keeps enable");
    repeat (3) @(negedge clk_i);
    chk_rd(3, 12'hF40, "R7 still pending");
    do_req(30'h0000_0000, "R7 still decodes while busy");
    err_clear();
    busy_i[3] = 1'b0;
    @(negedge clk_i);
    chk_rd(3, 12'hF00, "R7 applied when idle");
    m_en[3] = 1'b0;
    do_req(30'h0000_0000, "R7 region0 alone after disable");

    // R7: immediate disable when idle
    do_cfg(2, 12'h020);
    chk_rd(2, 12'h020, "R7 immediate disable");
    do_req(30'h2000_0000, "R7 disabled region no longer decodes");
    err_clear();

    // R10: bit 7 not stored
    do_cfg(4, 12'h1AA);
    chk_rd(4, 12'h12A, "R10 bit7 reads zero");

    // R9: error in same cycle as clear is captured
    @(negedge clk_i); req_i = 1'b1; addr_i = 30'h3000_0000; err_clr_i = 1'b1;
    sb_q.push_back('{cs: '0, err: 1'b1, tag: "R3 error during clear"});
    @(negedge clk_i); req_i = 1'b0; err_clr_i = 1'b0;
    chk_status(1'b1, 30'h3000_0000, '0, "R9 capture with clear");

    repeat (3) @(negedge clk_i);
    check(sb_q.size() == 0, "R2 scoreboard drained", 32'(sb_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule